// File: doc/BRIEF.md
# Resolution-programmable temperature conversion controller

This block paces temperature conversions and turns a raw signed sample into the 16-bit result word that software reads. A prescaler divides the clock into ticks. One conversion lasts a base number of ticks that doubles for each extra bit of resolution. When a conversion completes, the sample present on `sample_i` is captured, truncated to the selected resolution and stored, left-aligned and in two's complement. The analog converter itself sits outside this block.

In normal operation, conversions run back to back. Raising the shutdown input halts conversions only after the running conversion has finished and stored its result. While the block is shut down and idle, a one-shot strobe starts exactly one conversion. The block reports completion through three signals: a data-available flag, a one-cycle done pulse, and two read-driven toggle bits. The first toggle sits in the result LSB at reduced resolutions. The second is a separate control-register toggle.

Top module: `temp_conv_ctrl`

## Requirements
- R1: Resolution code `res_i` 0, 1, 2 and 3 selects 13, 14, 15 and 16 bits. In continuous mode a conversion lasts PRESCALE × BASE_TICKS × 2^code clock cycles, so done pulses are spaced by exactly that many cycles.
- R2: A completed conversion stores `sample_i` with bits [2-code:1] forced to zero and bits [15:3-code] kept. With code 3, all 16 bits are kept and bit 0 is the true LSB.
- R3: At codes 0 to 2, result bit 0 is a toggle. It inverts on a `rd_result_i` strobe only if a conversion has completed since the previous result read, and it stays unchanged otherwise.
- R4: `dav_o` rises in the cycle a conversion completes. A `rd_result_i` strobe clears it, unless a completion happens in the same cycle.
- R5: `done_o` is high for exactly one cycle per completed conversion. The new result and `dav_o` = 1 are visible in that same cycle.
- R6: Raising `shutdown_i` during a conversion does not shorten it. That conversion completes and stores its result, and no further conversion starts while `shutdown_i` stays high.
- R7: While shut down and idle, a `oneshot_i` strobe starts one conversion. Until it completes, `result_o` reads 8000h and `dav_o` reads 0. After completion the formatted sample replaces 8000h and no second conversion follows.
- R8: A `oneshot_i` strobe while `shutdown_i` is low has no effect: the result is not replaced by 8000h and `dav_o` is not cleared.
- R9: `ctrl_tog_o` inverts on a `rd_ctrl_i` strobe only if a conversion has completed since the previous control read, and it holds otherwise.
- R10: A change of `res_i` during a conversion does not alter that conversion's length. It applies from the next conversion.
- R11: After reset, `result_o` is 0000h, and `dav_o`, `ctrl_tog_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shutdown_i | input | 1 | Shutdown request; halts after the current conversion |
| oneshot_i | input | 1 | One-cycle strobe requesting a single conversion while shut down |
| res_i | input | 2 | Resolution code (0..3 = 13..16 bits) |
| sample_i | input | 16 | Raw signed sample, left-aligned |
| rd_result_i | input | 1 | One-cycle strobe marking a result-register read |
| rd_ctrl_i | input | 1 | One-cycle strobe marking a control-register read |
| result_o | output | 16 | Formatted result word |
| dav_o | output | 1 | Data-available flag |
| ctrl_tog_o | output | 1 | Control-register conversion toggle |
| done_o | output | 1 | One-cycle pulse after each completed conversion |

## Verification
A wrong tick count or a stale resolution in the timebase appears as a wrong spacing between done pulses, visible within one conversion period. A lost fresh-conversion flag shows up as a toggle bit that fails to invert on the first read after a completion, or that inverts again on a second back-to-back read. A sequencer that mishandles shutdown or one-shot either emits extra done pulses during a long quiet window, or fails to present 8000h with the data-available flag low in the cycle after the strobe.

// File: rtl/cvt_pkg.sv
`timescale 1ns/1ps
package cvt_pkg;

    typedef logic [1:0] res_code_t;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [15:0] word;
        res_code_t   code;
    } stored_result_t;

    localparam logic [15:0] ONESHOT_SENTINEL = 16'h8000;
    localparam res_code_t   FULL_RES_CODE    = 2'd3;

    // Bits kept for a given resolution code: [15:3-code]
    function automatic logic [15:0] keep_mask(input res_code_t code);
        return 16'hFFFF << (FULL_RES_CODE - code);
    endfunction

endpackage

// File: rtl/cvt_timebase.sv
`timescale 1ns/1ps
module cvt_timebase
    import cvt_pkg::*;
#(
    parameter int PRESCALE   = 1000,
    parameter int BASE_TICKS = 35
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      run,
    input  res_code_t code,
    output logic      fin
);
    localparam int PW       = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int TICK_MAX = BASE_TICKS * 8;
    localparam int TW       = $clog2(TICK_MAX + 1);

    logic [PW-1:0] pre_q;
    logic [TW-1:0] tick_q;
    logic [TW-1:0] limit;
    logic          pre_last;
    logic          tick_last;

    always_comb begin
        limit     = TW'(BASE_TICKS) << code;
        pre_last  = (pre_q == PW'(PRESCALE - 1));
        tick_last = (tick_q == (limit - TW'(1)));
        fin       = run && pre_last && tick_last;
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (run) begin
            if (pre_last) begin
                pre_q  <= '0;
                tick_q <= tick_q + TW'(1);
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end

endmodule

// File: rtl/cvt_sequencer.sv
`timescale 1ns/1ps
module cvt_sequencer
    import cvt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      shutdown_i,
    input  logic      oneshot_i,
    input  res_code_t res_i,
    input  logic      fin,
    output logic      start,
    output logic      os_start,
    output logic      run,
    output logic      os_busy,
    output res_code_t cur_code
);
    seq_state_e state_q;
    res_code_t  code_q;
    logic       os_q;

    always_comb begin
        start    = 1'b0;
        os_start = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (!shutdown_i) begin
                    start = 1'b1;
                end else if (oneshot_i) begin
                    start    = 1'b1;
                    os_start = 1'b1;
                end
            end
            SEQ_RUN: begin
                if (fin && !shutdown_i) start = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            code_q  <= '0;
            os_q    <= 1'b0;
        end else if (start) begin
            state_q <= SEQ_RUN;
            code_q  <= res_i;
            os_q    <= os_start;
        end else if (fin) begin
            state_q <= SEQ_IDLE;
            os_q    <= 1'b0;
        end
    end

    assign run      = (state_q == SEQ_RUN);
    assign os_busy  = os_q;
    assign cur_code = code_q;

endmodule

// File: rtl/cvt_result.sv
`timescale 1ns/1ps
module cvt_result
    import cvt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fin,
    input  res_code_t   code,
    input  logic        os_start,
    input  logic        os_busy,
    input  logic [15:0] sample_i,
    input  logic        rd_result_i,
    input  logic        rd_ctrl_i,
    output logic [15:0] result_o,
    output logic        dav_o,
    output logic        ctrl_tog_o
);
    stored_result_t stored_q;
    logic           res_tog_q, res_fresh_q;
    logic           ctl_tog_q, ctl_fresh_q;
    logic           dav_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q    <= '0;
            res_tog_q   <= 1'b0;
            res_fresh_q <= 1'b0;
            ctl_tog_q   <= 1'b0;
            ctl_fresh_q <= 1'b0;
            dav_q       <= 1'b0;
        end else begin
            if (fin) begin
                stored_q.word <= sample_i & keep_mask(code);
                stored_q.code <= code;
            end
            res_tog_q   <= res_tog_q ^ (rd_result_i && res_fresh_q);
            res_fresh_q <= fin || (res_fresh_q && !rd_result_i);
            ctl_tog_q   <= ctl_tog_q ^ (rd_ctrl_i && ctl_fresh_q);
            ctl_fresh_q <= fin || (ctl_fresh_q && !rd_ctrl_i);
            if (fin)                          dav_q <= 1'b1;
            else if (os_start || rd_result_i) dav_q <= 1'b0;
        end
    end

    always_comb begin
        if (os_busy) begin
            result_o = ONESHOT_SENTINEL;
        end else begin
            result_o[15:1] = stored_q.word[15:1];
            result_o[0]    = (stored_q.code == FULL_RES_CODE) ? stored_q.word[0] : res_tog_q;
        end
    end

    assign dav_o      = dav_q;
    assign ctrl_tog_o = ctl_tog_q;

endmodule

// File: rtl/temp_conv_ctrl.sv
`timescale 1ns/1ps
module temp_conv_ctrl
    import cvt_pkg::*;
#(
    parameter int PRESCALE   = 1000,
    parameter int BASE_TICKS = 35
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        shutdown_i,
    input  logic        oneshot_i,
    input  logic [1:0]  res_i,
    input  logic [15:0] sample_i,
    input  logic        rd_result_i,
    input  logic        rd_ctrl_i,
    output logic [15:0] result_o,
    output logic        dav_o,
    output logic        ctrl_tog_o,
    output logic        done_o
);
    logic      seq_start;
    logic      os_start;
    logic      seq_run;
    logic      os_busy;
    logic      conv_fin;
    res_code_t cur_code;
    logic      done_q;

    cvt_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .shutdown_i (shutdown_i),
        .oneshot_i  (oneshot_i),
        .res_i      (res_i),
        .fin        (conv_fin),
        .start      (seq_start),
        .os_start   (os_start),
        .run        (seq_run),
        .os_busy    (os_busy),
        .cur_code   (cur_code)
    );

    cvt_timebase #(
        .PRESCALE   (PRESCALE),
        .BASE_TICKS (BASE_TICKS)
    ) u_time (
        .clk   (clk),
        .rst   (rst),
        .start (seq_start),
        .run   (seq_run),
        .code  (cur_code),
        .fin   (conv_fin)
    );

    cvt_result u_res (
        .clk         (clk),
        .rst         (rst),
        .fin         (conv_fin),
        .code        (cur_code),
        .os_start    (os_start),
        .os_busy     (os_busy),
        .sample_i    (sample_i),
        .rd_result_i (rd_result_i),
        .rd_ctrl_i   (rd_ctrl_i),
        .result_o    (result_o),
        .dav_o       (dav_o),
        .ctrl_tog_o  (ctrl_tog_o)
    );

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= conv_fin;
    end

    assign done_o = done_q;

endmodule

// File: rtl/temp_conv_ctrl_chk.sv
`timescale 1ns/1ps
module temp_conv_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        shutdown_i,
    input logic        rd_ctrl_i,
    input logic [15:0] result_o,
    input logic        dav_o,
    input logic        ctrl_tog_o,
    input logic        done_o,
    input logic        seq_run,
    input logic        os_busy
);

    assert_done_sets_dav_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> dav_o);

    assert_dav_rise_with_done_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(dav_o) |-> done_o);

    assert_stop_only_in_shutdown_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(seq_run) |-> $past(shutdown_i));

    assert_sentinel_on_oneshot_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(os_busy) |-> (result_o == 16'h8000 && !dav_o));

    assert_ctrl_tog_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_ctrl_i |=> $stable(ctrl_tog_o));

endmodule

bind temp_conv_ctrl temp_conv_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .shutdown_i (shutdown_i),
    .rd_ctrl_i  (rd_ctrl_i),
    .result_o   (result_o),
    .dav_o      (dav_o),
    .ctrl_tog_o (ctrl_tog_o),
    .done_o     (done_o),
    .seq_run    (seq_run),
    .os_busy    (os_busy)
);

// File: tb/temp_conv_ctrl_test.sv
`timescale 1ns/1ps
module temp_conv_ctrl_test;

    localparam int PRESCALE   = 2;
    localparam int BASE_TICKS = 3;
    localparam int UNIT       = PRESCALE * BASE_TICKS;

    // {sample, code, expected stored word}
    localparam int NVEC = 6;
    localparam logic [33:0] VEC [NVEC] = '{
        {16'h0C85, 2'd0, 16'h0C80},
        {16'hFFFF, 2'd1, 16'hFFFC},
        {16'h4B03, 2'd2, 16'h4B02},
        {16'hEC01, 2'd3, 16'hEC01},
        {16'h5787, 2'd0, 16'h5780},
        {16'h8001, 2'd2, 16'h8000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        shutdown_i = 1'b0;
    logic        oneshot_i = 1'b0;
    logic [1:0]  res_i = 2'd0;
    logic [15:0] sample_i = 16'h0;
    logic        rd_result_i = 1'b0;
    logic        rd_ctrl_i = 1'b0;
    logic [15:0] result_o;
    logic        dav_o, ctrl_tog_o, done_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    temp_conv_ctrl #(.PRESCALE(PRESCALE), .BASE_TICKS(BASE_TICKS)) uut (
        .clk(clk), .rst(rst), .shutdown_i(shutdown_i), .oneshot_i(oneshot_i),
        .res_i(res_i), .sample_i(sample_i), .rd_result_i(rd_result_i),
        .rd_ctrl_i(rd_ctrl_i), .result_o(result_o), .dav_o(dav_o),
        .ctrl_tog_o(ctrl_tog_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done_o && n < 2000);
    endtask

    task automatic pulse_rd_result();
        rd_result_i = 1'b1;
        @(negedge clk);
        rd_result_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_rd_ctrl();
        rd_ctrl_i = 1'b1;
        @(negedge clk);
        rd_ctrl_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic count_quiet(input int cycles, output int pulses);
        pulses = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (done_o) pulses++;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int q;
        logic b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check(result_o == 16'h0000, "R11 result", result_o, 0);
        check(dav_o == 1'b0, "R11 dav", dav_o, 0);
        check(ctrl_tog_o == 1'b0, "R11 ctrl_tog", ctrl_tog_o, 0);
        check(done_o == 1'b0, "R11 done", done_o, 0);

        // Vector walk: R1 period, R2 format, R4 dav
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] s, e;
            logic [1:0]  c;
            {s, c, e} = VEC[v];
            sample_i = s;
            res_i    = c;
            wait_done(n);
            wait_done(n);
            check(n == (UNIT << c), "R1 conversion period", n, UNIT << c);
            if (c == 2'd3)
                check(result_o == e, "R2 full word", result_o, e);
            else
                check(result_o[15:1] == e[15:1], "R2 masked word", {result_o[15:1], 1'b0}, {e[15:1], 1'b0});
            check(dav_o == 1'b1, "R4 dav at done", dav_o, 1);
        end

        // Back to code 0 for directed tests
        res_i    = 2'd0;
        sample_i = 16'h0C85;
        wait_done(n);
        wait_done(n);

        // R5: done is a single-cycle pulse
        @(negedge clk);
        check(done_o == 1'b0, "R5 done one cycle", done_o, 0);

        // R3 / R4: result toggle and dav clear
        wait_done(n);
        b = result_o[0];
        pulse_rd_result();
        check(result_o[0] == ~b, "R3 toggle flips after fresh conversion", result_o[0], ~b);
        check(dav_o == 1'b0, "R4 dav cleared by read", dav_o, 0);
        pulse_rd_result();
        check(result_o[0] == ~b, "R3 toggle holds without new conversion", result_o[0], ~b);

        // R9: control toggle
        wait_done(n);
        b = ctrl_tog_o;
        pulse_rd_ctrl();
        check(ctrl_tog_o == ~b, "R9 ctrl toggle flips", ctrl_tog_o, ~b);
        pulse_rd_ctrl();
        check(ctrl_tog_o == ~b, "R9 ctrl toggle holds", ctrl_tog_o, ~b);

        // R8: one-shot ignored in continuous mode
        wait_done(n);
        oneshot_i = 1'b1;
        @(negedge clk);
        oneshot_i = 1'b0;
        check(result_o != 16'h8000, "R8 no sentinel", result_o, 16'h0C80);
        check(dav_o == 1'b1, "R8 dav kept", dav_o, 1);

        // R10: resolution change mid-conversion
        wait_done(n);
        @(negedge clk);
        res_i = 2'd3;
        wait_done(n);
        check(n == UNIT - 1, "R10 running conversion unchanged", n, UNIT - 1);
        res_i = 2'd0;
        wait_done(n);
        check(n == (UNIT << 3), "R10 next conversion uses new code", n, UNIT << 3);

        // R6: shutdown waits for running conversion
        wait_done(n);
        @(negedge clk);
        shutdown_i = 1'b1;
        sample_i   = 16'h2807;
        wait_done(n);
        check(n == UNIT - 1, "R6 conversion completes", n, UNIT - 1);
        check(result_o[15:1] == 15'(16'h2800 >> 1), "R6 result stored", result_o, 16'h2800);
        count_quiet(100, q);
        check(q == 0, "R6 no conversions in shutdown", q, 0);

        // R7: one-shot while shut down
        sample_i = 16'hEC0F;
        res_i    = 2'd2;
        oneshot_i = 1'b1;
        @(negedge clk);
        oneshot_i = 1'b0;
        check(result_o == 16'h8000, "R7 sentinel", result_o, 16'h8000);
        check(dav_o == 1'b0, "R7 dav low during one-shot", dav_o, 0);
        wait_done(n);
        check(n == (UNIT << 2), "R7 one-shot length", n, UNIT << 2);
        check(result_o[15:1] == 15'(16'hEC0E >> 1), "R7 final value", result_o, 16'hEC0E);
        check(dav_o == 1'b1, "R7 dav after one-shot", dav_o, 1);
        count_quiet(100, q);
        check(q == 0, "R7 single conversion only", q, 0);

        // R7 / R2: one-shot at full resolution
        sample_i = 16'h1235;
        res_i    = 2'd3;
        oneshot_i = 1'b1;
        @(negedge clk);
        oneshot_i = 1'b0;
        wait_done(n);
        check(result_o == 16'h1235, "R2 full-resolution one-shot", result_o, 16'h1235);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule